// File: doc/BRIEF.md
# Serial Shift-and-Latch Loader for an LED Grayscale Controller

This block is the serial loading front end of a multi-channel LED brightness controller. A host sends bits on a serial data line, and each rising edge of a slow shift clock moves them into a 48-bit common shift register. The top bit of that register drives the serial output, so several devices can be chained on one data line. A falling edge on a latch strobe copies the register into one of two destinations. The first is a 48-word grayscale store with one 16-bit word per channel, in three colour groups of sixteen. The second is a 48-bit function-control word.

All four external control lines are asynchronous to the system clock. These are the shift clock, the serial data, the strobe and the destination select. Each one passes through a two-stage synchroniser, and the block detects their edges in the system clock domain, so every register runs on one clock. A small state machine turns each detected event into a one-cycle action state:
- `ST_IDLE`: no event.
- `ST_SHIFT`: shift in one bit.
- `ST_LOAD_GS`: write one grayscale word.
- `ST_LOAD_FC`: write the function-control word.

Every state goes to `ST_LOAD_GS` or `ST_LOAD_FC` on a strobe fall, with the select choosing which. Without a strobe fall, a shift-clock rise leads to `ST_SHIFT`. Otherwise the next state is `ST_IDLE`.

Each grayscale write takes the low 16 bits of the shift register and stores them in the channel named by an internal write pointer. The pointer then advances and wraps from 47 back to 0. A combinational read port gives the PWM stage any stored word by address.

Top module: `led_serial_loader`

## Requirements
- R1: An active-low reset clears the shift register, the function-control word, all 48 grayscale words and the write pointer to zero. As a result `sout`, `fc_word` and every `gs_rd_data` read are 0.
- R2: A rising edge on `sclk_in` shifts the register one place toward bit 47 and puts `sin_in` into bit 0. `sout` always shows bit 47. The new value appears on `sout` at the third system clock edge after the first edge that samples the raised `sclk_in`.
- R3: Changes on `sin_in` with no `sclk_in` rise, and falling edges of `sclk_in`, leave the shift register unchanged.
- R4: A falling edge of `lat_in` with the destination select at 0 writes shift-register bits 15..0 into the grayscale word at the write pointer, then advances the pointer by one. The word is visible on the read port three system clock edges after the fall is first sampled.
- R5: The write pointer wraps from channel 47 back to channel 0. A 49th grayscale write therefore overwrites channel 0.
- R6: A falling edge of `lat_in` with the destination select at 1 copies all 48 shift-register bits to `fc_word`. It does not change any grayscale word or the write pointer.
- R7: A rising edge of `lat_in` has no effect. `fc_word` changes only on a function-control load.
- R8: A latch transfer does not alter the shift register, so `sout` and later shifts continue from its current contents.
- R9: When a `lat_in` fall and an `sclk_in` rise are sampled on the same system clock edge, the latch transfer takes place and that shift is dropped.
- R10: `gs_rd_data` shows the stored word at `gs_rd_addr` combinationally. It reads 0 for addresses 48 to 63.
- R11: `dest_fc` is synchronised together with `lat_in`, and its value at the sampled strobe fall picks the destination. A change of `dest_fc` one cycle after the fall does not alter that choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sin_in | input | 1 | Serial data in, asynchronous |
| lat_in | input | 1 | Latch strobe, transfer on falling edge |
| dest_fc | input | 1 | Destination select: 0 grayscale, 1 function control |
| sout | output | 1 | Shift register bit 47, for chaining |
| fc_word | output | 48 | Function-control word |
| gs_rd_addr | input | 6 | Grayscale read address for the PWM stage |
| gs_rd_data | output | 16 | Grayscale word at `gs_rd_addr` |

## Verification
A shift-register fault shows on `sout` once the bad bit reaches bit 47. A dropped or doubled shift misaligns the whole remaining stream, and every later function-control or grayscale load exposes it as a wrong word. A write-pointer fault puts words on the wrong channel. The sweeping read address shows this within 64 cycles of the load, and the 49th and 50th loads expose a faulty wrap. Select or priority faults show as an `fc_word` change, or a missing one, three cycles after the strobe fall.

// File: rtl/led_loader_pkg.sv
package led_loader_pkg;

    // One action state per detected event; ST_IDLE when nothing happened.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_LOAD_GS = 2'd2,
        ST_LOAD_FC = 2'd3
    } loader_state_t;

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gs_word_store.sv
module gs_word_store #(
    parameter int CHANNELS = 48,
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = $clog2(CHANNELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] wr_ptr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CHANNELS - 1);

    logic [WORD_W-1:0] mem [CHANNELS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CHANNELS; c++) mem[c] <= '0;
            wr_ptr <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < CHANNELS; c++)
                if (wr_ptr == ADDR_W'(c)) mem[c] <= wr_data;
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr <= LAST) rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/led_serial_loader.sv
module led_serial_loader
    import led_loader_pkg::*;
#(
    parameter int SR_W        = 48,
    parameter int CHANNELS    = 48,
    parameter int GS_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(CHANNELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sin_in,
    input  logic              lat_in,
    input  logic              dest_fc,
    output logic              sout,
    output logic [SR_W-1:0]   fc_word,
    input  logic [ADDR_W-1:0] gs_rd_addr,
    output logic [GS_W-1:0]   gs_rd_data
);

    localparam int B_SCLK = 0;
    localparam int B_SIN  = 1;
    localparam int B_LAT  = 2;
    localparam int B_SEL  = 3;

    // Synchronised control lines and edge detection
    logic [3:0] raw_in, lvl;
    logic       sclk_prev, lat_prev;
    logic       sclk_rise, lat_fall;

    assign raw_in = {dest_fc, lat_in, sin_in, sclk_in};

    sync_bank #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            lat_prev  <= 1'b0;
        end else begin
            sclk_prev <= lvl[B_SCLK];
            lat_prev  <= lvl[B_LAT];
        end
    end

    assign sclk_rise = lvl[B_SCLK] & ~sclk_prev;
    assign lat_fall  = ~lvl[B_LAT] & lat_prev;

    // State machine
    loader_state_t state, state_nxt;
    logic          shift_en, gs_we, fc_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_SHIFT, ST_LOAD_GS, ST_LOAD_FC: begin
                if (lat_fall)
                    state_nxt = lvl[B_SEL] ? ST_LOAD_FC : ST_LOAD_GS;
                else if (sclk_rise)
                    state_nxt = ST_SHIFT;
            end
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        gs_we    = 1'b0;
        fc_we    = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_SHIFT:   shift_en = 1'b1;
            ST_LOAD_GS: gs_we    = 1'b1;
            ST_LOAD_FC: fc_we    = 1'b1;
        endcase
    end

    // Datapath: common shift register and function-control latch
    logic [SR_W-1:0] shreg;
    logic            bit_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_hold <= 1'b0;
            fc_word  <= '0;
        end else begin
            if (sclk_rise) bit_hold <= lvl[B_SIN];
            if (shift_en)  shreg    <= {shreg[SR_W-2:0], bit_hold};
            if (fc_we)     fc_word  <= shreg;
        end
    end

    assign sout = shreg[SR_W-1];

    // Grayscale word store
    logic [ADDR_W-1:0] wr_ptr;

    gs_word_store #(.CHANNELS(CHANNELS), .WORD_W(GS_W), .ADDR_W(ADDR_W)) u_gs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (gs_we),
        .wr_data(shreg[GS_W-1:0]),
        .rd_addr(gs_rd_addr),
        .rd_data(gs_rd_data),
        .wr_ptr (wr_ptr)
    );

endmodule

// File: rtl/led_loader_checker.sv
module led_loader_checker
    import led_loader_pkg::*;
#(
    parameter int SR_W     = 48,
    parameter int CHANNELS = 48,
    parameter int ADDR_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input loader_state_t     state,
    input logic [SR_W-1:0]   shreg,
    input logic [SR_W-1:0]   fc_word,
    input logic [ADDR_W-1:0] wr_ptr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CHANNELS - 1);

    AST_SHREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |=> $stable(shreg)); // R3

    AST_SHREG_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> (shreg[SR_W-1:1] == $past(shreg[SR_W-2:0]))); // R2

    AST_FC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_FC) |=> (fc_word == $past(shreg))); // R6

    AST_FC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD_FC) |=> $stable(fc_word)); // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_GS) |=> (wr_ptr != $past(wr_ptr))); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD_GS) |=> $stable(wr_ptr)); // R6

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_GS && wr_ptr == LAST) |=> (wr_ptr == '0)); // R5

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr <= LAST)); // R5

endmodule

bind led_serial_loader led_loader_checker #(
    .SR_W(SR_W), .CHANNELS(CHANNELS), .ADDR_W(ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .shreg  (shreg),
    .fc_word(fc_word),
    .wr_ptr (wr_ptr)
);

// File: tb/tb_led_serial_loader.sv
module tb_led_serial_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0, sin_in = 1'b0, lat_in = 1'b0, dest_fc = 1'b0;
    logic        sout;
    logic [47:0] fc_word;
    logic [5:0]  gs_rd_addr = '0;
    logic [15:0] gs_rd_data;

    int  n_vec = 0, n_bad = 0;
    bit  done = 0, hold_addr = 0;

    always #4 clk = ~clk;  // 125 MHz

    led_serial_loader dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sin_in(sin_in),
        .lat_in(lat_in), .dest_fc(dest_fc), .sout(sout), .fc_word(fc_word),
        .gs_rd_addr(gs_rd_addr), .gs_rd_data(gs_rd_data)
    );

    // Behavioural reference: raw samples are seen three edges late
    logic [4:0]  hs = '0, hd = '0, hl = '0, hf = '0;
    logic [47:0] m_sr = '0, m_fc = '0;
    logic [15:0] m_gs [0:47];
    int          m_ptr = 0;

    initial for (int i = 0; i < 48; i++) m_gs[i] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hs = '0; hd = '0; hl = '0; hf = '0;
            m_sr = '0; m_fc = '0; m_ptr = 0;
            for (int i = 0; i < 48; i++) m_gs[i] = '0;
        end else begin
            hs = {hs[3:0], sclk_in};
            hd = {hd[3:0], sin_in};
            hl = {hl[3:0], lat_in};
            hf = {hf[3:0], dest_fc};
            if (hl[4] && !hl[3]) begin
                if (hf[3]) m_fc = m_sr;
                else begin
                    m_gs[m_ptr] = m_sr[15:0];
                    m_ptr = (m_ptr == 47) ? 0 : m_ptr + 1;
                end
            end else if (hs[3] && !hs[4]) begin
                m_sr = {m_sr[46:0], hd[3]};
            end
        end
    end

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model with a sweeping read address
    logic [5:0] sweep = '0;
    always @(negedge clk) begin
        if (!hold_addr) gs_rd_addr = sweep;
        sweep = sweep + 6'd1;
        #1;
        if (!done && !hold_addr) begin
            chk(rst_n ? "R2 sout" : "R1 sout", {47'd0, sout}, {47'd0, m_sr[47]});
            chk(rst_n ? "R6 fc_word" : "R1 fc_word", fc_word, m_fc);
            if (gs_rd_addr >= 6'd48) chk("R10 gs read", {32'd0, gs_rd_data}, 48'd0);
            else chk("R4 gs read", {32'd0, gs_rd_data}, {32'd0, m_gs[gs_rd_addr]});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sin_in = b; tick(4);
        sclk_in = 1'b1; tick(4);
        sclk_in = 1'b0; tick(4);
    endtask

    task automatic shift_bits(input logic [47:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    // Strobe pulse; select flips one cycle after the fall (R11)
    task automatic latch(input logic sel);
        dest_fc = sel; tick(2);
        lat_in = 1'b1; tick(4);
        lat_in = 1'b0; tick(1);
        dest_fc = ~sel; tick(8);
    endtask

    task automatic read_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        @(negedge clk); #2;
        hold_addr = 1; gs_rd_addr = a; #1;
        chk(tag, {32'd0, gs_rd_data}, {32'd0, exp});
        hold_addr = 0;
    endtask

    function automatic logic [15:0] gsw(input int i);
        return 16'(16'h1000 + i * 37);
    endfunction

    localparam logic [47:0] WA = 48'h9C3A_5E71_0FD2;
    localparam logic [47:0] WB = 48'h3E5D_A07C_61B4;

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1
        chk("R1 fc_word after reset", fc_word, 48'd0);
        chk("R1 sout after reset", {47'd0, sout}, 48'd0);
        read_chk("R1 gs word 5 after reset", 6'd5, 16'h0000);

        // R2, R6, R8
        shift_bits(WA, 48);
        chk("R2 sout shows first bit", {47'd0, sout}, {47'd0, WA[47]});
        latch(1'b1);
        chk("R6 fc load", fc_word, WA);
        chk("R8 sout kept after latch", {47'd0, sout}, {47'd0, WA[47]});

        // R3: data toggles without shift-clock rise
        for (int i = 0; i < 6; i++) begin sin_in = ~sin_in; tick(3); end
        latch(1'b1);
        chk("R3 no shift without sclk rise", fc_word, WA);

        // R7: strobe rise only
        dest_fc = 1'b1; lat_in = 1'b1; tick(8);
        chk("R7 strobe rise ignored", fc_word, WA);
        dest_fc = 1'b0; tick(2);
        lat_in = 1'b0; tick(8);  // grayscale write of WA[15:0] to channel 0
        read_chk("R4 first gs write", 6'd0, WA[15:0]);

        // R4, R5: 49 more grayscale loads, wrapping past channel 47
        for (int i = 1; i < 50; i++) begin
            shift_bits({32'd0, gsw(i)}, 16);
            latch(1'b0);
        end
        chk("R6 fc unaffected by gs loads", fc_word, WA);
        read_chk("R5 wrap overwrites ch0", 6'd0, gsw(48));
        read_chk("R5 wrap overwrites ch1", 6'd1, gsw(49));
        read_chk("R4 ch2 holds word 2", 6'd2, gsw(2));
        read_chk("R4 ch47 holds word 47", 6'd47, gsw(47));
        read_chk("R10 out of range read", 6'd55, 16'h0000);

        // R6, R11: fc load leaves pointer (now 2) alone
        shift_bits(WB, 48);
        latch(1'b1);
        chk("R11 select sampled at fall", fc_word, WB);
        latch(1'b0);
        read_chk("R6 pointer unchanged by fc load", 6'd2, WB[15:0]);
        read_chk("R6 ch3 untouched", 6'd3, gsw(3));

        // R9: strobe fall and shift rise together
        dest_fc = 1'b1; sin_in = 1'b1; lat_in = 1'b1; tick(6);
        lat_in = 1'b0; sclk_in = 1'b1; tick(6);
        sclk_in = 1'b0; tick(6);
        chk("R9 latch wins", fc_word, WB);
        chk("R9 shift dropped sout", {47'd0, sout}, {47'd0, WB[47]});
        latch(1'b1);
        chk("R9 register not shifted", fc_word, WB);

        // R2: one more shift moves bit 46 to the output
        shift_bit(1'b1);
        chk("R2 single shift", {47'd0, sout}, {47'd0, WB[46]});
        tick(70);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule